// File: doc/BRIEF.md
# Fault Status Test Loader

This block runs a diagnostic sequence that checks the path from a fault status register to the host. The host opens the sequence with a function request, which the block answers with a one-cycle acknowledge. The block then asks the host for an output word. Six bits of that word are copied into the fault status register, and a seventh status bit is formed from four more bits of the word. The block then raises an interrupt request while the assembled status word is on its output, and waits for the host to acknowledge it.

No real fault sources reach this block. Only the test values written by the host get to the status outputs, so the host can check every bit of the read-back path against a value it chose. The status bits stay in place after the sequence ends. They are cleared when a new sequence is entered or when a master clear arrives.

Top module: `fault_stat_loader`

## Requirements
- R1: After reset, every output is 0: `fn_ack`, `data_req`, `intr_req`, `stat_word` and `fault_flags`, and the block is idle.
- R2: While idle, a high `fn_req` sampled on a clock edge makes `fn_ack` high for exactly one cycle after that edge. `data_req` rises in the same cycle, and `fault_flags` and `stat_word` clear to 0.
- R3: `data_req` stays high until `data_ack` is sampled high. At that edge, output word bits 9..4 load `fault_flags[5:0]` and `stat_word[9:4]`, with word bit 4 going to flag bit 0.
- R4: At the accepting edge, `stat_word[10]` becomes the OR of output word bits 3..0.
- R5: After the accepting edge, `data_req` is low and `intr_req` is high. `intr_req` stays high until `intr_ack` is sampled high. `data_req` and `intr_req` are never high together.
- R6: A high `intr_ack` during the interrupt phase returns the block to idle in the next cycle with `intr_req` low. The loaded status stays unchanged while the block is idle.
- R7: `fn_req` outside idle, `data_ack` outside the data-request phase and `intr_ack` outside the interrupt phase are ignored. None of them changes the phase or the status.
- R8: `stat_word` bits 3..0 and bits above 10 are always 0, whatever the upper bits of the output word are.
- R9: A high `mclr` sampled on an edge takes priority over every other input. It returns the block to idle and clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mclr | input | 1 | Synchronous master clear |
| fn_req | input | 1 | Function request from the host; opens the sequence |
| fn_ack | output | 1 | One-cycle acknowledge of the function request |
| data_req | output | 1 | Request to the host for an output word |
| data_ack | input | 1 | Host strobe: `data_word` is valid |
| data_word | input | WORD_W | Output word from the host |
| intr_req | output | 1 | Interrupt request; `stat_word` is presented |
| intr_ack | input | 1 | Host acknowledge of the interrupt |
| stat_word | output | STAT_W | Instruction status word |
| fault_flags | output | 6 | Fault status register bits |

## Verification
The sequence is run with several output words:
- An all-ones fault field with a zero test nibble shows the two derived fields are independent.
- A zero fault field with a nonzero nibble does the same from the other side.
- A mixed word with its upper bits set shows the lane mapping and the zeroing of unused status positions.

Stray acknowledges in the wrong phase, a long host stall before `data_ack`, a re-entry after a completed sequence and a master clear in the middle of a sequence separate correct phase gating and clearing from simpler behaviour that would still pass the main path.

// File: rtl/fsl_pkg.sv
package fsl_pkg;
    localparam int FLT_LO   = 4;
    localparam int FLT_N    = 6;
    localparam int TST_LO   = 0;
    localparam int TST_N    = 4;
    localparam int TST_POS  = 10;

    typedef enum logic [1:0] {
        ST_IDLE        = 2'd0,
        ST_REQ_DATA    = 2'd1,
        ST_SEND_STATUS = 2'd2
    } fsl_state_e;

    typedef struct packed {
        fsl_state_e st;
        logic       ack;
    } ctrl_s;

    typedef struct packed {
        logic [FLT_N-1:0] flags;
        logic             tbit;
    } stat_s;
endpackage

// File: rtl/fsl_ctrl.sv
module fsl_ctrl
    import fsl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mclr,
    input  logic fn_req,
    input  logic data_ack,
    input  logic intr_ack,
    output logic fn_ack,
    output logic data_req,
    output logic intr_req,
    output logic load_en,
    output logic clr_en
);
    ctrl_s c_d, c_q;

    always_comb begin
        c_d     = c_q;
        c_d.ack = 1'b0;
        load_en = 1'b0;
        clr_en  = 1'b0;
        if (mclr) begin
            c_d.st = ST_IDLE;
            clr_en = 1'b1;
        end else begin
            unique case (c_q.st)
                ST_IDLE: if (fn_req) begin
                    c_d.st  = ST_REQ_DATA;
                    c_d.ack = 1'b1;
                    clr_en  = 1'b1;
                end
                ST_REQ_DATA: if (data_ack) begin
                    c_d.st  = ST_SEND_STATUS;
                    load_en = 1'b1;
                end
                ST_SEND_STATUS: if (intr_ack) begin
                    c_d.st = ST_IDLE;
                end
                default: c_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{st: ST_IDLE, ack: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    assign fn_ack   = c_q.ack;
    assign data_req = (c_q.st == ST_REQ_DATA);
    assign intr_req = (c_q.st == ST_SEND_STATUS);
endmodule

// File: rtl/fsl_stat_reg.sv
module fsl_stat_reg
    import fsl_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int STAT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic              clr_en,
    input  logic [WORD_W-1:0] word,
    output logic [FLT_N-1:0]  fault_flags,
    output logic [STAT_W-1:0] stat_word
);
    stat_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr_en) begin
            s_d = '0;
        end else if (load_en) begin
            s_d.flags = word[FLT_LO +: FLT_N];
            s_d.tbit  = |word[TST_LO +: TST_N];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // Place each status field on its lane; every other lane reads zero.
    for (genvar i = 0; i < STAT_W; i++) begin : g_lane
        if (i >= FLT_LO && i < FLT_LO + FLT_N) begin : g_flt
            assign stat_word[i] = s_q.flags[i-FLT_LO];
        end else if (i == TST_POS) begin : g_tst
            assign stat_word[i] = s_q.tbit;
        end else begin : g_zero
            assign stat_word[i] = 1'b0;
        end
    end

    assign fault_flags = s_q.flags;
endmodule

// File: rtl/fault_stat_loader.sv
module fault_stat_loader
    import fsl_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int STAT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mclr,
    input  logic              fn_req,
    output logic              fn_ack,
    output logic              data_req,
    input  logic              data_ack,
    input  logic [WORD_W-1:0] data_word,
    output logic              intr_req,
    input  logic              intr_ack,
    output logic [STAT_W-1:0] stat_word,
    output logic [5:0]        fault_flags
);
    logic load_en, clr_en;

    fsl_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .mclr     (mclr),
        .fn_req   (fn_req),
        .data_ack (data_ack),
        .intr_ack (intr_ack),
        .fn_ack   (fn_ack),
        .data_req (data_req),
        .intr_req (intr_req),
        .load_en  (load_en),
        .clr_en   (clr_en)
    );

    fsl_stat_reg #(
        .WORD_W (WORD_W),
        .STAT_W (STAT_W)
    ) u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_en     (load_en),
        .clr_en      (clr_en),
        .word        (data_word),
        .fault_flags (fault_flags),
        .stat_word   (stat_word)
    );
endmodule

// File: rtl/fsl_checker.sv
module fsl_checker #(
    parameter int WORD_W = 16,
    parameter int STAT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mclr,
    input logic              fn_req,
    input logic              fn_ack,
    input logic              data_req,
    input logic              data_ack,
    input logic [WORD_W-1:0] data_word,
    input logic              intr_req,
    input logic              intr_ack,
    input logic [STAT_W-1:0] stat_word,
    input logic [5:0]        fault_flags
);
    localparam logic [STAT_W-1:0] USED = STAT_W'(16'h07F0);

    assert_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fn_req && !data_req && !intr_req && !mclr |=> fn_ack && data_req && fault_flags == 6'd0);

    assert_ack_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fn_ack |=> !fn_ack);

    assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        data_req && data_ack && !mclr |=> intr_req && fault_flags == $past(data_word[9:4])
                                          && stat_word[9:4] == $past(data_word[9:4]));

    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        data_req && !data_ack && !mclr |=> data_req);

    assert_tbit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        data_req && data_ack && !mclr |=> stat_word[10] == (|$past(data_word[3:0])));

    assert_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({data_req, intr_req}));

    assert_intr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        intr_req && !intr_ack && !mclr |=> intr_req);

    assert_intr_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        intr_req && intr_ack |=> !intr_req && !data_req);

    assert_status_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !mclr && !(data_req && data_ack) && !(fn_req && !data_req && !intr_req)
        |=> $stable(fault_flags) && $stable(stat_word));

    assert_unused_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_word & ~USED) == '0);

    assert_mclr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mclr |=> !data_req && !intr_req && !fn_ack && fault_flags == 6'd0 && stat_word == '0);
endmodule

bind fault_stat_loader fsl_checker #(.WORD_W(WORD_W), .STAT_W(STAT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mclr        (mclr),
    .fn_req      (fn_req),
    .fn_ack      (fn_ack),
    .data_req    (data_req),
    .data_ack    (data_ack),
    .data_word   (data_word),
    .intr_req    (intr_req),
    .intr_ack    (intr_ack),
    .stat_word   (stat_word),
    .fault_flags (fault_flags)
);

// File: tb/fault_stat_loader_tb.sv
module fault_stat_loader_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WORD_W = 16;
    localparam int STAT_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mclr = 1'b0, fn_req = 1'b0, data_ack = 1'b0, intr_ack = 1'b0;
    logic [WORD_W-1:0] data_word = '0;
    logic fn_ack, data_req, intr_req;
    logic [STAT_W-1:0] stat_word;
    logic [5:0] fault_flags;

    int n_checks = 0;
    int n_errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    // behavioural reference: phase 0 idle, 1 waiting for word, 2 interrupt
    int       m_phase = 0;
    bit       m_ack = 1'b0;
    bit [5:0] m_flags = '0;
    bit       m_tbit = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fault_stat_loader #(.WORD_W(WORD_W), .STAT_W(STAT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .mclr(mclr), .fn_req(fn_req), .fn_ack(fn_ack),
        .data_req(data_req), .data_ack(data_ack), .data_word(data_word),
        .intr_req(intr_req), .intr_ack(intr_ack), .stat_word(stat_word),
        .fault_flags(fault_flags)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    function automatic logic [STAT_W-1:0] exp_stat(input bit [5:0] f, input bit t);
        logic [STAT_W-1:0] s;
        s = '0;
        s[9:4] = f;
        s[10] = t;
        return s;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (!rst_n || mclr) begin
            m_phase = 0; m_ack = 1'b0; m_flags = '0; m_tbit = 1'b0;
        end else begin
            m_ack = 1'b0;
            case (m_phase)
                0: if (fn_req) begin m_phase = 1; m_ack = 1'b1; m_flags = '0; m_tbit = 1'b0; end
                1: if (data_ack) begin m_phase = 2; m_flags = data_word[9:4]; m_tbit = |data_word[3:0]; end
                default: if (intr_ack) m_phase = 0;
            endcase
        end
    end

    // every-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2 model fn_ack", 32'(fn_ack), 32'(m_ack));
            check("R3 model data_req", 32'(data_req), 32'(m_phase == 1));
            check("R5 model intr_req", 32'(intr_req), 32'(m_phase == 2));
            check("R3 model fault_flags", 32'(fault_flags), 32'(m_flags));
            check("R8 model stat_word", 32'(stat_word), 32'(exp_stat(m_flags, m_tbit)));
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic enter();
        fn_req = 1'b1; tick(1); fn_req = 1'b0;
    endtask

    task automatic give_word(input logic [WORD_W-1:0] w);
        data_word = w; data_ack = 1'b1; tick(1); data_ack = 1'b0; data_word = '0;
    endtask

    task automatic ack_intr();
        intr_ack = 1'b1; tick(1); intr_ack = 1'b0;
    endtask

    initial begin
        tick(2);
        rst_n = 1'b1;
        tick(1);
        check("R1 reset outputs", {fn_ack, data_req, intr_req, fault_flags, stat_word}, 32'd0);

        // full sequence: all fault bits, zero test nibble
        enter();
        check("R2 fn_ack pulse", 32'(fn_ack), 32'd1);
        check("R2 data_req up", 32'(data_req), 32'd1);
        tick(1);
        check("R2 fn_ack single cycle", 32'(fn_ack), 32'd0);
        tick(3);
        check("R3 data_req held in stall", 32'(data_req), 32'd1);
        give_word(16'h03F0);
        check("R3 flags all set", 32'(fault_flags), 32'h3F);
        check("R4 tbit zero", 32'(stat_word[10]), 32'd0);
        check("R5 intr_req up", {data_req, intr_req}, 32'b01);
        tick(2);
        check("R5 intr_req held", 32'(intr_req), 32'd1);
        ack_intr();
        check("R6 back to idle", {data_req, intr_req}, 32'd0);
        tick(2);
        check("R6 status held idle", 32'(stat_word), 32'h03F0);

        // stray strobes while idle
        data_word = 16'h0000; data_ack = 1'b1; intr_ack = 1'b1; tick(1);
        data_ack = 1'b0; intr_ack = 1'b0;
        check("R7 idle data_ack ignored", 32'(stat_word), 32'h03F0);

        // re-entry clears; test nibble only
        enter();
        check("R2 entry clears status", 32'(stat_word), 32'd0);
        intr_ack = 1'b1; tick(1); intr_ack = 1'b0;
        check("R7 intr_ack in data phase ignored", 32'(data_req), 32'd1);
        give_word(16'h0005);
        check("R4 tbit set", 32'(stat_word), 32'h0400);
        fn_req = 1'b1; tick(1); fn_req = 1'b0;
        check("R7 fn_req in intr phase ignored", {fn_ack, intr_req}, 32'b01);
        ack_intr();

        // mixed word with upper bits
        enter();
        give_word(16'hFC28);
        check("R3 mixed flags", 32'(fault_flags), 32'h02);
        check("R8 upper lanes zero", 32'(stat_word), 32'h0420);
        ack_intr();

        // master clear mid sequence
        enter();
        give_word(16'h02A3);
        check("R9 pre-clear status", 32'(stat_word), 32'h06A0);
        mclr = 1'b1; fn_req = 1'b1; intr_ack = 1'b0; tick(1);
        mclr = 1'b0; fn_req = 1'b0;
        check("R9 master clear", {fn_ack, data_req, intr_req, fault_flags, stat_word}, 32'd0);
        enter();
        mclr = 1'b1; data_ack = 1'b1; data_word = 16'hFFFF; tick(1);
        mclr = 1'b0; data_ack = 1'b0;
        check("R9 clear beats data_ack", {data_req, intr_req, stat_word}, 32'd0);
        tick(2);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got hung expected finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule